// File: doc/BRIEF.md
# Dual-Bank Selectable Clock Divider

This block divides one fast input clock into two output banks. Each bank drives two identical true/complement output pairs. Bank A divides by 2 or 4, chosen by a single select bit. Bank B divides by 4, 5 or 6, chosen by a two-bit select. The design is intended for clock distribution logic that needs related slower clocks with a known phase relationship to the source.

An active-low asynchronous master reset clears both dividers. While reset is low, every true output is held low and every complement output is held high. An active-low output enable may change at any time. It passes through a synchronizer on the input clock. A bank starts or stops only on its own period boundary, so an output pulse is never cut short. A stopped bank parks with its true outputs low. When it restarts, its first phase is a full-width high phase. A change to a divide select also takes effect only at a period boundary.

Top module: `clk_div_banks`

## Requirements
- R1: Bank A period is 2 input cycles when `sel_a_i`=0 (1 high, 1 low) and 4 cycles when `sel_a_i`=1 (2 high, 2 low).
- R2: Bank B period follows `sel_b_i`: 2'b00 gives 4 cycles, 2'b01 gives 5, 2'b10 gives 6 and 2'b11 gives 5. The high phase lasts ceil(N/2) cycles, so ÷5 is 3 high and 2 low, ÷6 is 3/3 and ÷4 is 2/2.
- R3: While `rst_ni` is low, all true outputs are low and all complement outputs are high. Both take these values immediately when `rst_ni` falls, without waiting for a clock edge.
- R4: After `en_ni` goes high, each bank finishes its current period and then stops with its true outputs low. It stays stopped while `en_ni` remains high.
- R5: `en_ni` is sampled through two flops. If `en_ni` is low at rising edge k, a stopped bank drives its true outputs high after rising edge k+2. It begins with a full high phase.
- R6: When both banks are stopped and are enabled together, their first rising edges fall on the same input edge.
- R7: Both pairs in a bank always carry the same value, and each complement output is the inverse of its true output.
- R8: A select change made during a period does not alter that period. The new divide ratio applies from the next period boundary of that bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous master reset, active low |
| en_ni | input | 1 | Output enable, active low, asynchronous |
| sel_a_i | input | 1 | Bank A divide select |
| sel_b_i | input | 2 | Bank B divide select |
| qa_o | output | 2 | Bank A true outputs |
| qa_n_o | output | 2 | Bank A complement outputs |
| qb_o | output | 2 | Bank B true outputs |
| qb_n_o | output | 2 | Bank B complement outputs |

## Verification
Each cycle, the bench compares all outputs against a reference model of the period and enable rules. Directed cases cover the following:
- A select change in mid-period. A design that switched ratio at once would emit a short high or low phase.
- Disabling in mid-period. A design that stopped at once would leave a runt pulse.
- Restart after a stop. A design with the wrong synchronizer depth would start one edge early or late, or would start with a short high phase.
- The 2'b11 alias of bank B. A naive decoder would yield some other ratio.
- Reset asserted between clock edges. A design with a synchronous reset would leave the outputs switching until the next edge.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  localparam int unsigned CNT_W = 3;

  typedef logic [CNT_W-1:0] div_t;

  function automatic div_t dec_a(input logic sel);
    return sel ? div_t'(4) : div_t'(2);
  endfunction

  // 2'b11 aliases to divide-by-5
  function automatic div_t dec_b(input logic [1:0] sel);
    case (sel)
      2'b00:   return div_t'(4);
      2'b10:   return div_t'(6);
      default: return div_t'(5);
    endcase
  endfunction
endpackage

// File: rtl/clk_div_en_sync.sv
module clk_div_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  output logic run_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], ~en_ni};
  end

  assign run_o = sync_q[STAGES-1];
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank #(
  parameter int unsigned CW      = 3,
  parameter int unsigned DIV_RST = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] div_i,
  output logic          q_o,
  output logic          active_o
);
  logic          act_q, act_d, q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d, div_q, div_d;
  logic [CW:0]   hi_d;
  logic          wrap;

  assign wrap = act_q && (cnt_q == div_q - CW'(1));

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q + CW'(1);
    div_d = div_q;
    if (!act_q) begin
      cnt_d = '0;
      div_d = div_i;
      act_d = run_i;
    end else if (wrap) begin
      // period boundary: new ratio and enable state take effect here
      cnt_d = '0;
      div_d = div_i;
      act_d = run_i;
    end
    hi_d = ({1'b0, div_d} + (CW+1)'(1)) >> 1;
    q_d  = act_d && ({1'b0, cnt_d} < hi_d);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      div_q <= CW'(DIV_RST);
      q_q   <= 1'b0;
    end else begin
      act_q <= act_d;
      cnt_q <= cnt_d;
      div_q <= div_d;
      q_q   <= q_d;
    end
  end

  assign q_o      = q_q;
  assign active_o = act_q;

  p_start_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_q) |-> q_q);
  p_park_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_q |-> !q_q);
  p_div_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cnt_q != '0) |-> $stable(div_q));
  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q |-> (cnt_q < div_q));
endmodule

// File: rtl/clk_div_banks.sv
module clk_div_banks
  import clk_div_pkg::*;
#(
  parameter int unsigned NUM_PAIRS   = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_ni,
  input  logic                 sel_a_i,
  input  logic [1:0]           sel_b_i,
  output logic [NUM_PAIRS-1:0] qa_o,
  output logic [NUM_PAIRS-1:0] qa_n_o,
  output logic [NUM_PAIRS-1:0] qb_o,
  output logic [NUM_PAIRS-1:0] qb_n_o
);
  logic run, qa, qb, act_a, act_b;

  clk_div_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_ni(en_ni), .run_o(run)
  );

  clk_div_bank #(.CW(CNT_W), .DIV_RST(2)) u_bank_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(dec_a(sel_a_i)),
    .q_o(qa), .active_o(act_a)
  );

  clk_div_bank #(.CW(CNT_W), .DIV_RST(4)) u_bank_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(dec_b(sel_b_i)),
    .q_o(qb), .active_o(act_b)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign qa_o[p]   = qa;
    assign qa_n_o[p] = ~qa;
    assign qb_o[p]   = qb;
    assign qb_n_o[p] = ~qb;
  end

  p_align_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(act_a) && !$past(act_b)) |-> act_b);
  p_reset_out_r3: assert property (@(posedge clk_i)
    !rst_ni |-> (qa_o == '0 && qb_o == '0 && qa_n_o == '1 && qb_n_o == '1));
endmodule

// File: tb/clk_div_banks_tb.sv
module clk_div_banks_tb;
  logic       clk = 1'b0;
  logic       rst_ni, en_ni, sel_a;
  logic [1:0] sel_b;
  logic [1:0] qa, qa_n, qb, qb_n;
  int total = 0, bad = 0;
  bit done = 0;
  string tag_a = "R1", tag_b = "R2";

  // reference model state
  bit m_s1, m_s2;
  bit m_act[2], m_q[2];
  int m_cnt[2], m_div[2];

  always #4 clk = ~clk;

  clk_div_banks u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .qa_o(qa), .qa_n_o(qa_n), .qb_o(qb), .qb_n_o(qb_n)
  );

  function automatic int ref_div_a(bit s);
    return s ? 4 : 2;
  endfunction

  function automatic int ref_div_b(bit [1:0] s);
    case (s)
      2'b00: return 4;
      2'b01: return 5;
      2'b10: return 6;
      default: return 5;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit run;
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0;
      for (int b = 0; b < 2; b++) begin
        m_act[b] = 0; m_cnt[b] = 0; m_q[b] = 0; m_div[b] = (b == 0) ? 2 : 4;
      end
      return;
    end
    run = m_s2; m_s2 = m_s1; m_s1 = !en_ni;
    for (int b = 0; b < 2; b++) begin
      int req = (b == 0) ? ref_div_a(sel_a) : ref_div_b(sel_b);
      if (!m_act[b] || m_cnt[b] == m_div[b] - 1) begin
        m_act[b] = run; m_cnt[b] = 0; m_div[b] = req;
      end else m_cnt[b]++;
      m_q[b] = m_act[b] && (m_cnt[b] < (m_div[b] + 1) / 2);
    end
  endtask

  task automatic compare();
    chk(qa == {2{m_q[0]}}, tag_a, qa, {2{m_q[0]}});
    chk(qb == {2{m_q[1]}}, tag_b, qb, {2{m_q[1]}});
    chk(qa_n == ~qa && qb_n == ~qb, "R7", {qa_n, qb_n}, {~qa, ~qb});
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed = $urandom(32'd20240611);
    rst_ni = 0; en_ni = 1; sel_a = 0; sel_b = 2'b00;
    @(negedge clk);
    tick(); tick();
    // R3 reset state
    chk(qa == 2'b00 && qb == 2'b00 && qa_n == 2'b11 && qb_n == 2'b11, "R3",
        {qa, qb, qa_n, qb_n}, 8'h0f);
    rst_ni = 1;
    tick(); tick();

    // R5/R6: start latency and aligned start
    sel_a = 1; sel_b = 2'b10;
    en_ni = 0;
    tick(); tick();
    chk(qa == 0 && qb == 0, "R5", {qa, qb}, 0);
    tick();
    chk(qa == 2'b11, "R5", qa, 2'b11);
    chk(qb == 2'b11, "R6", qb, 2'b11);

    // R8: change ratio mid-period; current ÷6 period keeps 3 high
    tag_b = "R8";
    tick();
    sel_b = 2'b00;
    tick();
    chk(qb == 2'b11, "R8", qb, 2'b11);
    repeat (12) tick();
    tag_b = "R2";

    // R2 alias 11 -> ÷5, observe 3 high / 2 low via model
    sel_b = 2'b11;
    repeat (20) tick();
    sel_a = 0;
    repeat (10) tick();

    // R4: stop without runt, then stay parked
    en_ni = 1;
    repeat (10) tick();
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(qa == 0 && qb == 0 && qa_n == 2'b11 && qb_n == 2'b11, "R4", {qa, qb}, 0);
    end

    // R6 restart after full stop
    sel_b = 2'b01;
    en_ni = 0;
    repeat (3) tick();
    chk(qa == 2'b11 && qb == 2'b11, "R6", {qa, qb}, 4'hf);
    repeat (7) tick();

    // R3 asynchronous reset between edges
    #1 rst_ni = 0;
    #1 chk(qa == 0 && qb == 0 && qa_n == 2'b11 && qb_n == 2'b11, "R3",
           {qa, qb, qa_n, qb_n}, 8'h0f);
    @(negedge clk);
    tick();
    rst_ni = 1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 16 == 0) sel_a = $urandom % 2;
      if ($urandom % 13 == 0) sel_b = $urandom % 4;
      if ($urandom % 40 == 0) en_ni = ~en_ni;
      if ($urandom % 500 == 0) rst_ni = 0;
      tick();
      rst_ni = 1;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule